// File: doc/BRIEF.md
# Byte-Wide Slave Configuration Loader

This block is the host-side controller that pushes a configuration image into an FPGA whose configuration port is set to byte-wide slave parallel operation. Words arrive on a valid/ready stream. The loader first pulses the target's program line low and waits for the target to release its init line. It then places each word on a 16-bit parallel bus and frames the write with active-low chip select and write strobe. The target's busy line is checked before every write. After the last word the loader waits for the target's done line.

Two transfer variants are selected when a load starts. In the strobe-triggered (asynchronous) variant the target clocks the captured byte in by itself, and the loader only holds the strobe for a programmable number of system clocks. In the clocked (synchronous) variant the loader drives the configuration clock and emits a fixed burst of pulses for every byte on the bus. The bus width is 8 or 16 bits. A busy line that stays high too long aborts the load with a timeout flag. An init line that falls mid-load aborts it with a sticky error flag.

Top module: `slave_par_loader`

## Requirements
- R1: While reset is held, progN, csN and wrN are high, cclk is low, and inReady, finished, errInit and errTimeout are low.
- R2: A start in an idle, finished or failed state drives progN low for exactly PROG_CYCLES (4) clocks. No word is accepted until the target's init line is high after that pulse.
- R3: Words reach the bus in stream order. With wide=1 the whole 16-bit word appears on tgtData[15:0]. With wide=0 only bits 7:0 are driven from the word and tgtData[15:8] is zero.
- R4: csN falls only in the clock that follows a rising edge at which tgtBusy was low.
- R5: In asynchronous mode (syncMode=0), csN and wrN fall together and stay low for holdCycles clocks, with a value of 0 treated as 1. cclk stays low.
- R6: In synchronous mode (syncMode=1), csN and wrN stay low for 2×P clocks, where P is 8 pulses per byte (8 in byte mode, 16 in halfword mode). cclk alternates one clock low and one clock high, so it gives exactly P rising edges. cclk is low whenever csN is high.
- R7: tgtData holds its value for the clock after csN returns high.
- R8: inReady is high for one word at a time, only between writes and never while csN is low. The next word is taken only after the previous write has ended.
- R9: If tgtBusy is seen high on more than busyLimit consecutive edges while a word waits, errTimeout sets, no write takes place, and the flag remains set until the next start.
- R10: If tgtInit goes low after the init wait and before completion, errInit sets, writes stop, and the flag remains set until the next start.
- R11: finished rises only after the last word (tagged inLast) has been written and tgtDone is high.
- R12: wide, syncMode, holdCycles and busyLimit are captured at start. Changes to them during a load have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load sequence |
| wide | input | 1 | 1 = 16-bit words, 0 = bytes |
| syncMode | input | 1 | 1 = loader drives cclk bursts, 0 = strobe-triggered |
| holdCycles | input | 8 | Strobe low time in asynchronous mode |
| busyLimit | input | 16 | Longest busy wait before timeout |
| inData | input | 16 | Stream word |
| inValid | input | 1 | Stream word valid |
| inLast | input | 1 | Marks the final word |
| inReady | output | 1 | Loader takes the word this cycle |
| tgtProgN | output | 1 | Target program request, active low |
| tgtInit | input | 1 | Target init status, low during clearing or on error |
| tgtDone | input | 1 | Target configuration complete |
| tgtBusy | input | 1 | Target busy handshake |
| tgtCsN | output | 1 | Chip select, active low |
| tgtWrN | output | 1 | Write strobe, active low |
| tgtCclk | output | 1 | Configuration clock in synchronous mode |
| tgtData | output | 16 | Parallel configuration data |
| finished | output | 1 | Load completed |
| errInit | output | 1 | Sticky init-drop error |
| errTimeout | output | 1 | Sticky busy-timeout error |

## Verification
The hardest situations to reach from the ports are the aborts in the middle of a load. The init line must fall while words are still moving, and the busy line must stay high for longer than the limit at the exact point a word is waiting. The bench contains a behavioural target that answers program with an init-low window and toggles busy at random. On command it pins busy high or forces init low once a chosen number of words has been captured. A later clean load confirms that the sticky flags clear only on start.

// File: rtl/spl_pkg.sv
package spl_pkg;

  typedef enum logic [3:0] {
    S_IDLE, S_PROG, S_INIT, S_FETCH, S_BUSY,
    S_WRITE, S_REL, S_DONEW, S_DONE, S_ERR
  } spl_state_t;

  typedef struct packed {
    logic latchMode;
    logic loadWord;
    logic clrCnt;
    logic incCnt;
  } dp_strobe_t;

endpackage

// File: rtl/spl_datapath.sv
module spl_datapath
  import spl_pkg::*;
#(
  parameter int DATA_W = 16,
  parameter int BYTE_W = 8,
  parameter int CNT_W  = 16,
  parameter int HOLD_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  dp_strobe_t        strobe,
  input  logic              wide,
  input  logic              syncMode,
  input  logic [HOLD_W-1:0] holdCycles,
  input  logic [CNT_W-1:0]  busyLimit,
  input  logic [DATA_W-1:0] inData,
  input  logic              inLast,
  output logic [CNT_W-1:0]  cnt,
  output logic              wideQ,
  output logic              syncQ,
  output logic [HOLD_W-1:0] holdQ,
  output logic [CNT_W-1:0]  limitQ,
  output logic              lastQ,
  output logic [DATA_W-1:0] dataBus
);

  localparam int LANES = DATA_W / BYTE_W;

  logic [DATA_W-1:0] dataReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wideQ  <= 1'b0;
      syncQ  <= 1'b0;
      holdQ  <= '0;
      limitQ <= '0;
    end else if (strobe.latchMode) begin
      wideQ  <= wide;
      syncQ  <= syncMode;
      holdQ  <= holdCycles;
      limitQ <= busyLimit;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
      lastQ   <= 1'b0;
    end else if (strobe.loadWord) begin
      dataReg <= inData;
      lastQ   <= inLast;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.clrCnt) cnt <= '0;
    else if (strobe.incCnt) cnt <= cnt + 1'b1;
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    if (g == 0) begin : g_low
      assign dataBus[g*BYTE_W +: BYTE_W] = dataReg[g*BYTE_W +: BYTE_W];
    end else begin : g_high
      assign dataBus[g*BYTE_W +: BYTE_W] = wideQ ? dataReg[g*BYTE_W +: BYTE_W] : '0;
    end
  end

  // R12: captured mode only moves on a latch strobe
  p_mode_hold_r12: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.latchMode |=> $stable(wideQ) && $stable(syncQ));

  p_cnt_clear: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clrCnt |=> cnt == '0);

endmodule

// File: rtl/spl_ctrl.sv
module spl_ctrl
  import spl_pkg::*;
#(
  parameter int PROG_CYCLES = 4,
  parameter int CNT_W       = 16,
  parameter int HOLD_W      = 8,
  parameter int PULSES      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              inValid,
  input  logic              tgtInit,
  input  logic              tgtBusy,
  input  logic              tgtDone,
  input  logic [CNT_W-1:0]  cnt,
  input  logic              wideQ,
  input  logic              syncQ,
  input  logic [HOLD_W-1:0] holdQ,
  input  logic [CNT_W-1:0]  limitQ,
  input  logic              lastQ,
  output dp_strobe_t        strobe,
  output logic              inReady,
  output logic              tgtProgN,
  output logic              tgtCsN,
  output logic              tgtWrN,
  output logic              tgtCclk,
  output logic              finished,
  output logic              errInit,
  output logic              errTimeout
);

  localparam logic [CNT_W-1:0] PROG_LAST   = CNT_W'(PROG_CYCLES - 1);
  localparam logic [CNT_W-1:0] BURST_BYTE  = CNT_W'(2 * PULSES - 1);
  localparam logic [CNT_W-1:0] BURST_HALF  = CNT_W'(4 * PULSES - 1);

  spl_state_t state, stateNext;
  logic setInitErr, setTimeout, clearFlags;
  logic [CNT_W-1:0] writeLast;
  logic loadActive;

  always_comb begin
    if (syncQ)           writeLast = wideQ ? BURST_HALF : BURST_BYTE;
    else if (holdQ == 0) writeLast = '0;
    else                 writeLast = CNT_W'(holdQ) - 1'b1;
  end

  assign loadActive = (state == S_FETCH) || (state == S_BUSY) || (state == S_WRITE) ||
                      (state == S_REL)   || (state == S_DONEW);

  always_comb begin
    stateNext  = state;
    strobe     = '0;
    setInitErr = 1'b0;
    setTimeout = 1'b0;
    clearFlags = 1'b0;
    if (loadActive && !tgtInit) begin
      stateNext  = S_ERR;
      setInitErr = 1'b1;
    end else begin
      case (state)
        S_IDLE, S_DONE, S_ERR: if (start) begin
          stateNext        = S_PROG;
          strobe.latchMode = 1'b1;
          strobe.clrCnt    = 1'b1;
          clearFlags       = 1'b1;
        end
        S_PROG: begin
          strobe.incCnt = 1'b1;
          if (cnt == PROG_LAST) stateNext = S_INIT;
        end
        S_INIT: if (tgtInit) stateNext = S_FETCH;
        S_FETCH: if (inValid) begin
          strobe.loadWord = 1'b1;
          strobe.clrCnt   = 1'b1;
          stateNext       = S_BUSY;
        end
        S_BUSY: begin
          if (!tgtBusy) begin
            strobe.clrCnt = 1'b1;
            stateNext     = S_WRITE;
          end else if (cnt >= limitQ) begin
            setTimeout = 1'b1;
            stateNext  = S_ERR;
          end else begin
            strobe.incCnt = 1'b1;
          end
        end
        S_WRITE: begin
          strobe.incCnt = 1'b1;
          if (cnt == writeLast) stateNext = S_REL;
        end
        S_REL:   stateNext = lastQ ? S_DONEW : S_FETCH;
        S_DONEW: if (tgtDone) stateNext = S_DONE;
        default: stateNext = S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state      <= S_IDLE;
      errInit    <= 1'b0;
      errTimeout <= 1'b0;
    end else begin
      state <= stateNext;
      if (clearFlags) begin
        errInit    <= 1'b0;
        errTimeout <= 1'b0;
      end else begin
        if (setInitErr) errInit    <= 1'b1;
        if (setTimeout) errTimeout <= 1'b1;
      end
    end
  end

  assign inReady  = (state == S_FETCH) && tgtInit;
  assign tgtProgN = (state != S_PROG);
  assign tgtCsN   = (state != S_WRITE);
  assign tgtWrN   = (state != S_WRITE);
  assign tgtCclk  = (state == S_WRITE) && syncQ && cnt[0];
  assign finished = (state == S_DONE);

  // R4: a write opens only after an edge that saw busy low
  p_no_write_busy_r4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(tgtCsN) |-> !$past(tgtBusy));

  // R10: init error survives until a new start
  p_init_sticky_r10: assert property (@(posedge clk) disable iff (!rstN)
    errInit && !start |=> errInit);

  // R8: no stream acceptance during a write
  p_ready_idle_r8: assert property (@(posedge clk) disable iff (!rstN)
    inReady |-> tgtCsN && tgtProgN);

  // R6: clock pulses only inside a clocked write
  p_cclk_window_r6: assert property (@(posedge clk) disable iff (!rstN)
    tgtCclk |-> !tgtCsN && syncQ);

  // R9: after timeout nothing is written
  p_timeout_quiet_r9: assert property (@(posedge clk) disable iff (!rstN)
    errTimeout |-> tgtCsN);

endmodule

// File: rtl/slave_par_loader.sv
module slave_par_loader
  import spl_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int BYTE_W      = 8,
  parameter int CNT_W       = 16,
  parameter int HOLD_W      = 8,
  parameter int PROG_CYCLES = 4,
  parameter int PULSES      = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              start,
  input  logic              wide,
  input  logic              syncMode,
  input  logic [HOLD_W-1:0] holdCycles,
  input  logic [CNT_W-1:0]  busyLimit,
  input  logic [DATA_W-1:0] inData,
  input  logic              inValid,
  input  logic              inLast,
  output logic              inReady,
  output logic              tgtProgN,
  input  logic              tgtInit,
  input  logic              tgtDone,
  input  logic              tgtBusy,
  output logic              tgtCsN,
  output logic              tgtWrN,
  output logic              tgtCclk,
  output logic [DATA_W-1:0] tgtData,
  output logic              finished,
  output logic              errInit,
  output logic              errTimeout
);

  dp_strobe_t        strobe;
  logic [CNT_W-1:0]  cnt;
  logic              wideQ, syncQ, lastQ;
  logic [HOLD_W-1:0] holdQ;
  logic [CNT_W-1:0]  limitQ;

  spl_datapath #(
    .DATA_W(DATA_W), .BYTE_W(BYTE_W), .CNT_W(CNT_W), .HOLD_W(HOLD_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .wide(wide), .syncMode(syncMode),
    .holdCycles(holdCycles), .busyLimit(busyLimit), .inData(inData), .inLast(inLast),
    .cnt(cnt), .wideQ(wideQ), .syncQ(syncQ), .holdQ(holdQ), .limitQ(limitQ),
    .lastQ(lastQ), .dataBus(tgtData)
  );

  spl_ctrl #(
    .PROG_CYCLES(PROG_CYCLES), .CNT_W(CNT_W), .HOLD_W(HOLD_W), .PULSES(PULSES)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start), .inValid(inValid), .tgtInit(tgtInit),
    .tgtBusy(tgtBusy), .tgtDone(tgtDone), .cnt(cnt), .wideQ(wideQ), .syncQ(syncQ),
    .holdQ(holdQ), .limitQ(limitQ), .lastQ(lastQ), .strobe(strobe), .inReady(inReady),
    .tgtProgN(tgtProgN), .tgtCsN(tgtCsN), .tgtWrN(tgtWrN), .tgtCclk(tgtCclk),
    .finished(finished), .errInit(errInit), .errTimeout(errTimeout)
  );

  // R7: bus keeps its value for the clock after a write ends
  p_bus_stable_r7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(tgtCsN) |=> $stable(tgtData));

endmodule

// File: tb/tb_slave_par_loader.sv
module tb_slave_par_loader;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic        wide = 1'b0;
  logic        syncMode = 1'b0;
  logic [7:0]  holdCycles = 8'd1;
  logic [15:0] busyLimit = 16'd20;
  logic [15:0] inData = '0;
  logic        inValid = 1'b0;
  logic        inLast = 1'b0;
  logic        inReady;
  logic        tgtProgN;
  logic        tgtInit = 1'b0;
  logic        tgtDone = 1'b0;
  logic        tgtBusy = 1'b0;
  logic        tgtCsN, tgtWrN, tgtCclk;
  logic [15:0] tgtData;
  logic        finished, errInit, errTimeout;

  slave_par_loader dut (
    .clk(clk), .rstN(rstN), .start(start), .wide(wide), .syncMode(syncMode),
    .holdCycles(holdCycles), .busyLimit(busyLimit), .inData(inData), .inValid(inValid),
    .inLast(inLast), .inReady(inReady), .tgtProgN(tgtProgN), .tgtInit(tgtInit),
    .tgtDone(tgtDone), .tgtBusy(tgtBusy), .tgtCsN(tgtCsN), .tgtWrN(tgtWrN),
    .tgtCclk(tgtCclk), .tgtData(tgtData), .finished(finished), .errInit(errInit),
    .errTimeout(errTimeout)
  );

  always #10 clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  logic [15:0] arr [64];
  int streamLen = 0, idx = 0, capIdx = 0;
  bit streamOn = 0, acceptPend = 0;
  bit curWide = 0, curSync = 0;
  int curHold = 1;
  bit busyRand = 0, busyStuck = 0, initForceLow = 0, doneEn = 1;
  int initDly = 0;
  bit prevCsN = 1, prevCclk = 0, prevProgN = 1, stableArm = 0;
  int lowLen = 0, pulses = 0, progLow = 0;
  logic [15:0] heldData;

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] expWord(input logic [15:0] w, input bit wd);
    return wd ? w : {8'h00, w[7:0]};
  endfunction

  function automatic int expLen(input bit s, input bit wd, input int h);
    if (s) return wd ? 32 : 16;
    return (h == 0) ? 1 : h;
  endfunction

  function automatic int expPulses(input bit s, input bit wd);
    if (!s) return 0;
    return wd ? 16 : 8;
  endfunction

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++; checks++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 150000);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
    if (rstN) begin
      // R2 program pulse width
      if (!tgtProgN) progLow++;
      else if (!prevProgN) begin
        chk(progLow == 4, "R2 prog width", progLow, 4);
        progLow = 0;
      end
      if (inReady && (!tgtProgN || !tgtInit)) chk(0, "R2 ready before init", 1, 0);
      if (stableArm) begin
        chk(tgtData == heldData, "R7 bus hold", tgtData, heldData);
        stableArm = 0;
      end
      if (!tgtCsN && prevCsN) begin
        chk(!tgtBusy, "R4 busy at write", tgtBusy, 0);
        chk(tgtData == expWord(arr[capIdx % 64], curWide), "R3 word", tgtData,
            expWord(arr[capIdx % 64], curWide));
        capIdx++;
        lowLen = 0;
        pulses = 0;
      end
      if (!tgtCsN) begin
        lowLen++;
        if (tgtCclk && !prevCclk) pulses++;
        if (tgtWrN) chk(0, "R5 strobe with select", tgtWrN, 0);
        if (inReady) chk(0, "R8 ready in write", 1, 0);
      end else if (tgtCclk) begin
        chk(0, "R6 cclk outside write", 1, 0);
      end
      if (tgtCsN && !prevCsN && !errInit) begin
        chk(lowLen == expLen(curSync, curWide, curHold), curSync ? "R6 window" : "R5 hold",
            lowLen, expLen(curSync, curWide, curHold));
        chk(pulses == expPulses(curSync, curWide), "R6 pulses", pulses,
            expPulses(curSync, curWide));
        heldData = tgtData;
        stableArm = 1;
      end
    end
    prevCsN = tgtCsN; prevCclk = tgtCclk; prevProgN = tgtProgN;

    // stream driver
    if (acceptPend) idx++;
    inValid = streamOn && (idx < streamLen);
    inData  = arr[idx % 64];
    inLast  = (idx == streamLen - 1);
    acceptPend = inValid && inReady;

    // target model
    if (!tgtProgN) begin
      tgtInit = 1'b0;
      initDly = 3;
    end else if (initDly > 0) initDly--;
    else tgtInit = 1'b1;
    if (initForceLow) tgtInit = 1'b0;
    tgtBusy = busyStuck ? 1'b1 : (busyRand ? (($urandom % 3) == 0) : 1'b0);
    tgtDone = doneEn && streamLen > 0 && capIdx == streamLen && tgtCsN;
  end

  task automatic beginLoad(input int n, input bit w, input bit s, input int h);
    for (int i = 0; i < n; i++) arr[i] = 16'($urandom);
    curWide = w; curSync = s; curHold = h;
    wide = w; syncMode = s; holdCycles = 8'(h);
    capIdx = 0; idx = 0; streamLen = n; acceptPend = 0; streamOn = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
  endtask

  task automatic waitEnd(input int maxCyc);
    for (int i = 0; i < maxCyc; i++) begin
      @(negedge clk);
      if (finished || errInit || errTimeout) break;
    end
  endtask

  task automatic runLoad(input int n, input bit w, input bit s, input int h);
    beginLoad(n, w, s, h);
    waitEnd(20000);
    chk(finished, "R11 finished", finished, 1);
    chk(capIdx == n, "R3 word count", capIdx, n);
    chk(!errInit && !errTimeout, "R10 flags clear on start", {errInit, errTimeout}, 0);
    streamOn = 0;
  endtask

  initial begin
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(tgtProgN && tgtCsN && tgtWrN && !tgtCclk, "R1 pins", {tgtProgN, tgtCsN, tgtWrN, tgtCclk}, 4'b1110);
    chk(!inReady && !finished && !errInit && !errTimeout, "R1 status",
        {inReady, finished, errInit, errTimeout}, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    busyRand = 1;
    runLoad(20, 0, 0, 3);
    runLoad(16, 1, 0, 1);
    runLoad(6, 0, 0, 0);
    runLoad(10, 0, 1, 2);
    runLoad(10, 1, 1, 2);
    for (int r = 0; r < 4; r++)
      runLoad(4 + ($urandom % 12), 1'($urandom), 1'($urandom), 1 + ($urandom % 5));

    // R12 mode change mid-load is ignored
    beginLoad(12, 0, 1, 2);
    repeat (20) @(negedge clk);
    wide = 1'b1; syncMode = 1'b0; holdCycles = 8'd7;
    waitEnd(20000);
    chk(finished && capIdx == 12, "R12 mode captured", capIdx, 12);
    streamOn = 0;

    // R11 done gating
    doneEn = 0;
    beginLoad(5, 1, 0, 2);
    for (int i = 0; i < 2000 && capIdx < 5; i++) @(negedge clk);
    repeat (30) @(negedge clk);
    chk(!finished, "R11 waits for done", finished, 0);
    doneEn = 1;
    repeat (5) @(negedge clk);
    chk(finished, "R11 done seen", finished, 1);
    streamOn = 0;

    // R9 busy timeout
    busyLimit = 16'd10;
    busyRand = 0; busyStuck = 1;
    beginLoad(5, 0, 0, 2);
    repeat (40) @(negedge clk);
    chk(errTimeout, "R9 timeout", errTimeout, 1);
    chk(capIdx == 0, "R9 no write", capIdx, 0);
    busyStuck = 0;
    repeat (10) @(negedge clk);
    chk(errTimeout && capIdx == 0 && !inReady, "R9 sticky", errTimeout, 1);
    streamOn = 0;
    busyLimit = 16'd20;
    busyRand = 1;

    // R10 init drop mid-load
    beginLoad(20, 1, 0, 2);
    for (int i = 0; i < 4000 && capIdx < 6; i++) @(negedge clk);
    initForceLow = 1;
    repeat (5) @(negedge clk);
    initForceLow = 0;
    repeat (20) @(negedge clk);
    chk(errInit, "R10 init error", errInit, 1);
    chk(!finished && capIdx <= 7, "R10 writes stop", capIdx, 7);
    chk(tgtCsN && !inReady, "R10 idle after error", {tgtCsN, inReady}, 2'b10);
    streamOn = 0;
    runLoad(8, 0, 1, 1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule